// File: doc/BRIEF.md
# Multi-Mode PCM Serial Port

This block is the serial front end of a two-channel voice processor. It converts 8-bit serial PCM samples on four line directions into parallel bytes: incoming receive-path samples (r-in) and send-path samples (s-in), and outgoing receive-path (r-out) and send-path (s-out) samples. All timing comes from an external bit clock and 8 kHz frame syncs. The bit clock, the syncs and the serial inputs are resynchronised into the system clock domain, and bit-clock edges are found there. Serial outputs are modelled as a data bit plus an active-high output enable. The enable is low outside the active bit slots, during reset and during power-down.

A 2-bit mode code reroutes the pins. In parallel mode each channel has its own pins and its own sync. In serial mode both channels share the channel-1 pins in a 16-bit frame timed from sync 1. In cross-connected mode both channels use sync 1, but only the r-out and s-in pins of each channel are in use.

Received bytes go to the core as valid-only streams. Line data cannot be stalled, so there is no ready; the core must accept each one-cycle valid pulse. Transmit bytes enter through valid/ready streams, one per output lane. Each lane holds one byte and drops ready while that byte is held. A byte offered while ready is low waits with valid high until the held byte is taken.

Top module: `pcm_mux_port`

## Requirements
- R1: After reset every output enable is low, both transmit ready vectors are all ones, and no receive valid or frame strobe is asserted.
- R2: A frame starts at the first falling bit-clock edge at which sync is high after it was low at the previous falling edge. A sync held high over several bits starts only one frame. Input bits are taken on falling edges, most significant bit first. Each channel's r-in and s-in bytes are presented together with one rx_valid pulse after that channel's eighth bit.
- R3: A transmit slot begins at the rising bit-clock edge at which sync is first seen high. The enable is high for exactly 8 bit periods per byte, and the data bit changes on rising edges, most significant bit first.
- R4: In mode 00 (parallel), channel 1 uses sync1, rin1, sin1, rout1 and sout1, and channel 2 uses sync2, rin2, sin2, rout2 and sout2, each with its own timing.
- R5: In mode 01 (serial), one 16-bit frame timed from sync1 carries channel 1 in bits 0–7 and channel 2 in bits 8–15 on rin1/sin1/rout1/sout1. The rout2 and sout2 enables stay low, and rin2, sin2 and sync2 are ignored.
- R6: In mode 10 (cross-connected), both channels use sync1. Channel 1 uses sin1 and rout1, and channel 2 uses sin2 and rout2. The sout1 and sout2 enables stay low, rin1 and rin2 read as zero, and the r-in bytes are 8'h00.
- R7: In mode 11 (inhibited), no frame starts: all enables stay low and no receive valid appears.
- R8: While pwr_dn is high, no frame starts and all enables are low. A byte held for transmit is kept and is sent in the first frame after pwr_dn falls.
- R9: Each transmit lane holds one byte and its ready is low while the byte is held. The byte is taken when its slot starts. A slot that starts with no held byte sends 8'h00.
- R10: frame_strobe[c] pulses once per frame when channel c's first bit is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_dn | input | 1 | Power-down: stops framing, enables low |
| mode | input | 2 | 00 parallel, 01 serial, 10 cross-connected, 11 inhibited |
| sck | input | 1 | PCM bit clock |
| sync1 | input | 1 | Channel-1 frame sync |
| sync2 | input | 1 | Channel-2 frame sync (parallel mode only) |
| rin1 | input | 1 | Serial r-in, pin 1 |
| sin1 | input | 1 | Serial s-in, pin 1 |
| rin2 | input | 1 | Serial r-in, pin 2 |
| sin2 | input | 1 | Serial s-in, pin 2 |
| rout1 | output | 1 | Serial r-out data, pin 1 |
| rout1_oe | output | 1 | Output enable of rout1 |
| sout1 | output | 1 | Serial s-out data, pin 1 |
| sout1_oe | output | 1 | Output enable of sout1 |
| rout2 | output | 1 | Serial r-out data, pin 2 |
| rout2_oe | output | 1 | Output enable of rout2 |
| sout2 | output | 1 | Serial s-out data, pin 2 |
| sout2_oe | output | 1 | Output enable of sout2 |
| frame_strobe | output | 2 | Per-channel frame start pulse |
| rx_valid | output | 2 | Per-channel received-byte pulse |
| rx_rbyte | output | 16 | r-in bytes, channel c at [8c+7:8c] |
| rx_sbyte | output | 16 | s-in bytes, channel c at [8c+7:8c] |
| rt_valid | input | 2 | r-out byte offer per channel |
| rt_data | input | 16 | r-out bytes, channel c at [8c+7:8c] |
| rt_ready | output | 2 | r-out lane can take a byte |
| st_valid | input | 2 | s-out byte offer per channel |
| st_data | input | 16 | s-out bytes, channel c at [8c+7:8c] |
| st_ready | output | 2 | s-out lane can take a byte |

## Verification
The assertions assume three things about the inputs. The mode code and the frame length it implies do not change while a frame is in flight. Each bit-clock phase lasts several system clocks, so edges are seen one at a time. Sync stays low between frames long enough for its next rise to be seen. The stimulus changes mode and pwr_dn only between frames, while sync is low. It drives the bit clock with 8 system clocks per phase, and it changes sync and data only together with the bit-clock rise. Outputs are read at the end of each high phase, and received bytes are collected on every clock.

// File: rtl/pcm_mux_pkg.sv
package pcm_mux_pkg;
  localparam int BYTE_W = 8;
  localparam int SLOTS  = 2;
  typedef enum logic [1:0] {
    MODE_PAR  = 2'b00,
    MODE_SER  = 2'b01,
    MODE_XCON = 2'b10,
    MODE_OFF  = 2'b11
  } pcm_mode_e;
endpackage

// File: rtl/pcm_line_sync.sv
module pcm_line_sync #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         rise,
  output logic         fall
);
  logic [W-1:0] meta, stab;
  logic         clk_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta  <= '0;
      stab  <= '0;
      clk_d <= 1'b0;
    end else begin
      meta  <= d;
      stab  <= meta;
      clk_d <= stab[0];
    end
  end

  assign q    = stab;
  assign rise = stab[0] & ~clk_d;
  assign fall = ~stab[0] & clk_d;
endmodule

// File: rtl/pcm_frame_timer.sv
module pcm_frame_timer #(
  parameter int BW    = 8,
  parameter int SLOTS = 2,
  localparam int FL   = BW * SLOTS,
  localparam int IW   = $clog2(FL),
  localparam int LW   = $clog2(FL + 1),
  localparam int BB   = $clog2(BW),
  localparam int SW   = IW - BB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          rise,
  input  logic          fall,
  input  logic          sync,
  input  logic [LW-1:0] len,
  output logic          rx_stb,
  output logic [IW-1:0] rx_idx,
  output logic          tx_act,
  output logic [IW-1:0] tx_idx,
  output logic          tx_ld,
  output logic [SW-1:0] tx_ld_slot
);
  logic          s_fall, s_rise, rx_act;
  logic [LW-1:0] rx_cnt;
  logic [IW-1:0] tx_idx_q, tx_nxt;
  logic          tx_act_q, rx_start, rx_go, tx_start, tx_go, tx_last;

  assign rx_start = run & fall & sync & ~s_fall;
  assign rx_go    = run & fall & rx_act & ~rx_start;
  assign rx_stb   = rx_start | rx_go;
  assign rx_idx   = rx_start ? '0 : rx_cnt[IW-1:0];

  assign tx_start = run & rise & sync & ~s_rise;
  assign tx_go    = run & rise & tx_act_q & ~tx_start;
  assign tx_nxt   = tx_idx_q + 1'b1;
  assign tx_last  = (LW'(tx_idx_q) == len - LW'(1));
  assign tx_ld    = tx_start | (tx_go & ~tx_last & (tx_nxt[BB-1:0] == '0));
  assign tx_ld_slot = tx_start ? '0 : tx_nxt[IW-1:BB];
  assign tx_act   = tx_act_q;
  assign tx_idx   = tx_idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_fall <= 1'b0;  s_rise <= 1'b0;
      rx_act <= 1'b0;  rx_cnt <= '0;
      tx_act_q <= 1'b0; tx_idx_q <= '0;
    end else begin
      if (fall) s_fall <= sync;
      if (rise) s_rise <= sync;
      if (!run) begin
        rx_act   <= 1'b0;
        tx_act_q <= 1'b0;
      end else begin
        if (rx_start) begin
          rx_act <= 1'b1;
          rx_cnt <= LW'(1);
        end else if (rx_go) begin
          rx_cnt <= rx_cnt + 1'b1;
          if (rx_cnt == len - LW'(1)) rx_act <= 1'b0;
        end
        if (tx_start) begin
          tx_act_q <= 1'b1;
          tx_idx_q <= '0;
        end else if (tx_go) begin
          if (tx_last) tx_act_q <= 1'b0;
          else         tx_idx_q <= tx_nxt;
        end
      end
    end
  end

  // R3: a transmit window closes only after its last bit index
  a_r3_window_len: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(tx_act_q) && $past(run)) |-> (LW'($past(tx_idx_q)) == len - LW'(1)));

  // R8: a stopped timer carries no frame
  a_r8_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!tx_act_q && !rx_act));
endmodule

// File: rtl/pcm_rx_lane.sv
module pcm_rx_lane #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb,
  input  logic          first,
  input  logic          last,
  input  logic          bit_r,
  input  logic          bit_s,
  output logic          valid,
  output logic          fstrobe,
  output logic [BW-1:0] rbyte,
  output logic [BW-1:0] sbyte
);
  logic [BW-1:0] sr, ss;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr <= '0; ss <= '0; rbyte <= '0; sbyte <= '0;
      valid <= 1'b0; fstrobe <= 1'b0;
    end else begin
      valid   <= stb & last;
      fstrobe <= stb & first;
      if (stb) begin
        sr <= {sr[BW-2:0], bit_r};
        ss <= {ss[BW-2:0], bit_s};
        if (last) begin
          rbyte <= {sr[BW-2:0], bit_r};
          sbyte <= {ss[BW-2:0], bit_s};
        end
      end
    end
  end

  // R2: a received byte is announced for a single cycle
  a_r2_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);
endmodule

// File: rtl/pcm_tx_lane.sv
module pcm_tx_lane #(
  parameter int BW = 8,
  localparam int BB = $clog2(BW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [BW-1:0] in_data,
  output logic          in_ready,
  input  logic          ld,
  input  logic [BB-1:0] bsel,
  output logic          bit_o
);
  logic [BW-1:0] hold, cur;
  logic          full;

  assign in_ready = ~full;
  assign bit_o    = cur[BW-1-int'(bsel)];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold <= '0; cur <= '0; full <= 1'b0;
    end else begin
      if (ld) cur <= full ? hold : '0;
      if (ld && full) begin
        full <= 1'b0;
      end else if (in_valid && !full) begin
        full <= 1'b1;
        hold <= in_data;
      end
    end
  end

  // R9: a held byte stays put until its slot takes it
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !ld) |=> (full && $stable(hold)));
endmodule

// File: rtl/pcm_mux_port.sv
module pcm_mux_port
  import pcm_mux_pkg::*;
#(
  parameter int BW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_dn,
  input  logic [1:0]    mode,
  input  logic          sck,
  input  logic          sync1,
  input  logic          sync2,
  input  logic          rin1,
  input  logic          sin1,
  input  logic          rin2,
  input  logic          sin2,
  output logic          rout1,
  output logic          rout1_oe,
  output logic          sout1,
  output logic          sout1_oe,
  output logic          rout2,
  output logic          rout2_oe,
  output logic          sout2,
  output logic          sout2_oe,
  output logic [1:0]    frame_strobe,
  output logic [1:0]    rx_valid,
  output logic [2*BW-1:0] rx_rbyte,
  output logic [2*BW-1:0] rx_sbyte,
  input  logic [1:0]    rt_valid,
  input  logic [2*BW-1:0] rt_data,
  output logic [1:0]    rt_ready,
  input  logic [1:0]    st_valid,
  input  logic [2*BW-1:0] st_data,
  output logic [1:0]    st_ready
);
  localparam int FL = BW * SLOTS;
  localparam int IW = $clog2(FL);
  localparam int LW = $clog2(FL + 1);
  localparam int BB = $clog2(BW);
  localparam int SW = IW - BB;

  pcm_mode_e md;
  assign md = pcm_mode_e'(mode);

  logic [6:0] ln;
  logic       sck_r, sck_f;
  pcm_line_sync #(.W(7)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({sin2, rin2, sin1, rin1, sync2, sync1, sck}),
    .q(ln), .rise(sck_r), .fall(sck_f)
  );

  logic          t_run   [2];
  logic          t_sync  [2];
  logic [LW-1:0] t_len   [2];
  logic          t_rx_stb[2];
  logic [IW-1:0] t_rx_idx[2];
  logic          t_tx_act[2];
  logic [IW-1:0] t_tx_idx[2];
  logic          t_tx_ld [2];
  logic [SW-1:0] t_tx_slot[2];

  always_comb begin
    t_run[0]  = ~pwr_dn & (md != MODE_OFF);
    t_run[1]  = ~pwr_dn & (md == MODE_PAR);
    t_sync[0] = ln[1];
    t_sync[1] = ln[2];
    t_len[0]  = (md == MODE_SER) ? LW'(FL) : LW'(BW);
    t_len[1]  = LW'(BW);
  end

  for (genvar t = 0; t < 2; t++) begin : g_tmr
    pcm_frame_timer #(.BW(BW), .SLOTS(SLOTS)) u_tmr (
      .clk(clk), .rst_n(rst_n), .run(t_run[t]),
      .rise(sck_r), .fall(sck_f), .sync(t_sync[t]), .len(t_len[t]),
      .rx_stb(t_rx_stb[t]), .rx_idx(t_rx_idx[t]),
      .tx_act(t_tx_act[t]), .tx_idx(t_tx_idx[t]),
      .tx_ld(t_tx_ld[t]), .tx_ld_slot(t_tx_slot[t])
    );
  end

  logic rbit_i[2], sbit_i[2], rbit_o[2], sbit_o[2];

  always_comb begin
    rbit_i[0] = (md == MODE_XCON) ? 1'b0 : ln[3];
    rbit_i[1] = (md == MODE_PAR) ? ln[5] : ((md == MODE_SER) ? ln[3] : 1'b0);
    sbit_i[0] = ln[4];
    sbit_i[1] = (md == MODE_SER) ? ln[4] : ln[6];
  end

  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic          ts, sl, stb, ld;
    logic [IW-1:0] ridx, tidx;
    assign ts   = (c == 1) && (md == MODE_PAR);
    assign sl   = (c == 1) && (md == MODE_SER);
    assign ridx = t_rx_idx[ts];
    assign tidx = t_tx_idx[ts];
    assign stb  = t_rx_stb[ts] && (ridx[IW-1:BB] == SW'(sl));
    assign ld   = t_tx_ld[ts] && (t_tx_slot[ts] == SW'(sl));

    pcm_rx_lane #(.BW(BW)) u_rx (
      .clk(clk), .rst_n(rst_n), .stb(stb),
      .first(ridx[BB-1:0] == '0), .last(ridx[BB-1:0] == BB'(BW-1)),
      .bit_r(rbit_i[c]), .bit_s(sbit_i[c]),
      .valid(rx_valid[c]), .fstrobe(frame_strobe[c]),
      .rbyte(rx_rbyte[c*BW +: BW]), .sbyte(rx_sbyte[c*BW +: BW])
    );

    pcm_tx_lane #(.BW(BW)) u_rt (
      .clk(clk), .rst_n(rst_n),
      .in_valid(rt_valid[c]), .in_data(rt_data[c*BW +: BW]), .in_ready(rt_ready[c]),
      .ld(ld), .bsel(tidx[BB-1:0]), .bit_o(rbit_o[c])
    );

    pcm_tx_lane #(.BW(BW)) u_st (
      .clk(clk), .rst_n(rst_n),
      .in_valid(st_valid[c]), .in_data(st_data[c*BW +: BW]), .in_ready(st_ready[c]),
      .ld(ld), .bsel(tidx[BB-1:0]), .bit_o(sbit_o[c])
    );
  end

  logic slot_a;
  assign slot_a = (t_tx_idx[0][IW-1:BB] != '0);

  always_comb begin
    rout1_oe = t_tx_act[0];
    sout1_oe = t_tx_act[0] & (md != MODE_XCON);
    rout2_oe = (md == MODE_PAR) ? t_tx_act[1] : ((md == MODE_XCON) ? t_tx_act[0] : 1'b0);
    sout2_oe = (md == MODE_PAR) & t_tx_act[1];
    rout1 = rout1_oe & ((md == MODE_SER && slot_a) ? rbit_o[1] : rbit_o[0]);
    sout1 = sout1_oe & ((md == MODE_SER && slot_a) ? sbit_o[1] : sbit_o[0]);
    rout2 = rout2_oe & rbit_o[1];
    sout2 = sout2_oe & sbit_o[1];
  end

  // R5: the channel-2 timer stays idle outside parallel mode
  a_r5_ch2_timer_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (md != MODE_PAR) |=> !t_tx_act[1]);
endmodule

// File: tb/tb_pcm_mux_port.sv
module tb_pcm_mux_port;
  localparam int HALF = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, pwr_dn, sck, sync1, sync2, rin1, sin1, rin2, sin2;
  logic [1:0] mode;
  logic rout1, rout1_oe, sout1, sout1_oe, rout2, rout2_oe, sout2, sout2_oe;
  logic [1:0] frame_strobe, rx_valid, rt_valid, rt_ready, st_valid, st_ready;
  logic [15:0] rx_rbyte, rx_sbyte, rt_data, st_data;

  pcm_mux_port dut (.*);

  int nchk = 0, nerr = 0;
  int nv[2], nfs[2];
  logic [7:0] rb_last[2], sb_last[2];
  logic [31:0] p_s1, p_s2, p_r1, p_si1, p_r2, p_si2;
  logic [31:0] c_r1, e_r1, c_s1, e_s1, c_r2, e_r2, c_s2, e_s2;

  always @(negedge clk) begin
    for (int c = 0; c < 2; c++) begin
      if (rx_valid[c]) begin
        nv[c]++;
        rb_last[c] = rx_rbyte[c*8 +: 8];
        sb_last[c] = rx_sbyte[c*8 +: 8];
      end
      if (frame_strobe[c]) nfs[c]++;
    end
  end

  task automatic chk(string tag, logic [31:0] a, logic [31:0] e);
    nchk++;
    if (a !== e) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, a, e);
    end
  endtask

  function automatic logic [31:0] oe_of(int st);
    logic [31:0] v = '0;
    if (st >= 0) for (int i = 0; i < 8; i++) v[st+i] = 1'b1;
    return v;
  endfunction

  function automatic logic [31:0] bits_of(int st, logic [7:0] b);
    logic [31:0] v = '0;
    for (int i = 0; i < 8; i++) v[st+i] = b[7-i];
    return v;
  endfunction

  task automatic put(ref logic [31:0] p, input int st, input logic [7:0] b);
    for (int i = 0; i < 8; i++) p[st+i] = b[7-i];
  endtask

  task automatic chk_pin(string tag, logic [31:0] cb, logic [31:0] ce,
                         logic [31:0] eoe, logic [31:0] eb, int n);
    logic [31:0] m = (32'd1 << n) - 32'd1;
    chk({tag, " enable"}, ce & m, eoe & m);
    chk({tag, " data"}, cb & ce & m, eb & m);
  endtask

  task automatic clr();
    p_s1 = '0; p_s2 = '0; p_r1 = '0; p_si1 = '0; p_r2 = '0; p_si2 = '0;
    c_r1 = '0; e_r1 = '0; c_s1 = '0; e_s1 = '0;
    c_r2 = '0; e_r2 = '0; c_s2 = '0; e_s2 = '0;
    for (int c = 0; c < 2; c++) begin
      nv[c] = 0; nfs[c] = 0; rb_last[c] = '0; sb_last[c] = '0;
    end
  endtask

  task automatic run_periods(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      sck = 1'b1;
      sync1 = p_s1[k]; sync2 = p_s2[k];
      rin1 = p_r1[k]; sin1 = p_si1[k]; rin2 = p_r2[k]; sin2 = p_si2[k];
      repeat (HALF) @(negedge clk);
      c_r1[k] = rout1; e_r1[k] = rout1_oe; c_s1[k] = sout1; e_s1[k] = sout1_oe;
      c_r2[k] = rout2; e_r2[k] = rout2_oe; c_s2[k] = sout2; e_s2[k] = sout2_oe;
      sck = 1'b0;
      repeat (HALF) @(negedge clk);
    end
    sync1 = 1'b0; sync2 = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic offer_r(int c, logic [7:0] b);
    @(negedge clk);
    rt_valid[c] = 1'b1; rt_data[c*8 +: 8] = b;
    @(negedge clk);
    rt_valid[c] = 1'b0;
  endtask

  task automatic offer_s(int c, logic [7:0] b);
    @(negedge clk);
    st_valid[c] = 1'b1; st_data[c*8 +: 8] = b;
    @(negedge clk);
    st_valid[c] = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pwr_dn = 1'b0; mode = 2'b00; sck = 1'b0;
    sync1 = 0; sync2 = 0; rin1 = 0; sin1 = 0; rin2 = 0; sin2 = 0;
    rt_valid = '0; st_valid = '0; rt_data = '0; st_data = '0;
    clr();
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 enables", {rout1_oe, sout1_oe, rout2_oe, sout2_oe}, 4'b0);
    chk("R1 ready", {rt_ready, st_ready}, 4'b1111);
    chk("R1 valid/strobe", {rx_valid, frame_strobe}, 4'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R4 parallel mode, channel 2 offset by 3 bits
    mode = 2'b00; clr();
    offer_r(0, 8'hA5); offer_s(0, 8'h3C); offer_r(1, 8'hC3); offer_s(1, 8'h5A);
    chk("R9 ready low while held", {rt_ready, st_ready}, 4'b0);
    p_s1[0] = 1; p_s2[3] = 1;
    put(p_r1, 0, 8'h96); put(p_si1, 0, 8'h1E); put(p_r2, 3, 8'h71); put(p_si2, 3, 8'hE8);
    run_periods(14);
    chk_pin("R4 R3 rout1", c_r1, e_r1, oe_of(0), bits_of(0, 8'hA5), 14);
    chk_pin("R4 R3 sout1", c_s1, e_s1, oe_of(0), bits_of(0, 8'h3C), 14);
    chk_pin("R4 rout2", c_r2, e_r2, oe_of(3), bits_of(3, 8'hC3), 14);
    chk_pin("R4 sout2", c_s2, e_s2, oe_of(3), bits_of(3, 8'h5A), 14);
    chk("R2 R4 ch1 valid count", nv[0], 1);
    chk("R2 R4 ch2 valid count", nv[1], 1);
    chk("R2 ch1 bytes", {rb_last[0], sb_last[0]}, 16'h961E);
    chk("R4 ch2 bytes", {rb_last[1], sb_last[1]}, 16'h71E8);
    chk("R10 strobes parallel", {nfs[0][3:0], nfs[1][3:0]}, 8'h11);
    chk("R9 ready back after slot", {rt_ready, st_ready}, 4'b1111);

    // R9 empty hold sends zero; R2 long sync starts one frame
    clr();
    p_s1[0] = 1; p_s1[1] = 1; p_s1[2] = 1;
    put(p_r1, 0, 8'hC5);
    p_r1[8] = 1; p_r1[9] = 1;
    run_periods(12);
    chk_pin("R9 rout1 zero byte", c_r1, e_r1, oe_of(0), '0, 12);
    chk("R2 long sync one byte", nv[0], 1);
    chk("R2 long sync data", rb_last[0], 8'hC5);
    chk("R4 ch2 idle without sync2", nv[1] + e_r2, 0);

    // R5 serial mode
    mode = 2'b01; clr();
    offer_r(0, 8'h81); offer_r(1, 8'h7E); offer_s(0, 8'h11); offer_s(1, 8'hEE);
    p_s1[0] = 1; p_s2[3] = 1;
    put(p_r1, 0, 8'h2B); put(p_r1, 8, 8'hD4); put(p_si1, 0, 8'h67); put(p_si1, 8, 8'h99);
    p_r2 = 32'hFFFF_FFFF; p_si2 = 32'hFFFF_FFFF;
    run_periods(20);
    chk_pin("R5 rout1", c_r1, e_r1, oe_of(0) | oe_of(8),
            bits_of(0, 8'h81) | bits_of(8, 8'h7E), 20);
    chk_pin("R5 sout1", c_s1, e_s1, oe_of(0) | oe_of(8),
            bits_of(0, 8'h11) | bits_of(8, 8'hEE), 20);
    chk_pin("R5 rout2 off", c_r2, e_r2, '0, '0, 20);
    chk_pin("R5 sout2 off", c_s2, e_s2, '0, '0, 20);
    chk("R5 ch1 bytes", {rb_last[0], sb_last[0]}, 16'h2B67);
    chk("R5 ch2 bytes", {rb_last[1], sb_last[1]}, 16'hD499);
    chk("R10 strobes serial", {nfs[0][3:0], nfs[1][3:0]}, 8'h11);

    // R6 cross-connected mode
    mode = 2'b10; clr();
    offer_r(0, 8'hE1); offer_r(1, 8'h1E); offer_s(0, 8'h55); offer_s(1, 8'hAA);
    p_s1[0] = 1;
    p_r1 = 32'hFFFF_FFFF; p_r2 = 32'hFFFF_FFFF;
    put(p_si1, 0, 8'h4D); put(p_si2, 0, 8'hB2);
    run_periods(12);
    chk_pin("R6 rout1", c_r1, e_r1, oe_of(0), bits_of(0, 8'hE1), 12);
    chk_pin("R6 rout2", c_r2, e_r2, oe_of(0), bits_of(0, 8'h1E), 12);
    chk_pin("R6 sout1 off", c_s1, e_s1, '0, '0, 12);
    chk_pin("R6 sout2 off", c_s2, e_s2, '0, '0, 12);
    chk("R6 ch1 bytes", {rb_last[0], sb_last[0]}, 16'h004D);
    chk("R6 ch2 bytes", {rb_last[1], sb_last[1]}, 16'h00B2);

    // R7 inhibited mode
    mode = 2'b11; clr();
    offer_r(0, 8'h77);
    p_s1[0] = 1; p_s2[0] = 1; put(p_r1, 0, 8'hF0);
    run_periods(12);
    chk("R7 enables", e_r1 | e_s1 | e_r2 | e_s2, 0);
    chk("R7 no valid", nv[0] + nv[1], 0);
    chk("R7 byte still held", rt_ready[0], 1'b0);

    // R8 power-down, then release
    mode = 2'b00; pwr_dn = 1'b1; clr();
    p_s1[0] = 1; p_s2[0] = 1; put(p_r1, 0, 8'h0F);
    run_periods(12);
    chk("R8 enables", e_r1 | e_s1 | e_r2 | e_s2, 0);
    chk("R8 no valid", nv[0] + nv[1] + nfs[0] + nfs[1], 0);
    chk("R8 byte kept", rt_ready[0], 1'b0);
    pwr_dn = 1'b0; clr();
    p_s1[0] = 1;
    run_periods(10);
    chk_pin("R8 held byte sent", c_r1, e_r1, oe_of(0), bits_of(0, 8'h77), 10);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule